// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer Controller

An 8-bit up-counting timer that either guards software as a watchdog or paces it as an interval timer. Software reaches three byte-wide registers (count, control/status, reset control) over a simple register bus. Every write carries a key in the upper data byte, so a stray store cannot reload or disable the timer. A prescaler gives the count one of eight increment rates.

In watchdog mode, a count that passes 0xFF drives an active-low alarm output low for a fixed 132 clocks. It also returns the count and the control fields to their reset values and sets the overflow flag. When reset generation is enabled, an internal reset request is raised for 518 clocks. While the alarm is low, all register writes are refused and a read of the flag is not taken as the first step of the clear sequence. In interval mode, the wrap sets the flag and raises an interrupt request that holds until software clears the flag. The flag clears only when software reads the control/status register while the alarm is high and then writes 0 to the flag bit.

The block also turns a CPU low-power request into a grant. A deep (standby) request is demoted to sleep while the timer is guarding as an enabled watchdog.

The alarm sequencer has four states. `AL_WATCH` is normal counting. `AL_PULSE` holds the alarm low without reset. `AL_PULSE_RST` holds the alarm low with the reset request raised. `AL_RST_TAIL` keeps the reset request up after the alarm has returned high.

Its transitions are:
- watchdog trip: `AL_WATCH`→`AL_PULSE` when reset is disabled, `AL_WATCH`→`AL_PULSE_RST` when it is enabled.
- pulse end: `AL_PULSE`→`AL_WATCH` and `AL_PULSE_RST`→`AL_RST_TAIL`, after 132 clocks in the state.
- reset end: `AL_RST_TAIL`→`AL_WATCH`, 518 clocks after the trip.

The power decider has three states: `PWR_RUN` (00), `PWR_SLEEP` (01) and `PWR_STBY` (10). It re-evaluates every clock.

Top module: `wdt_guard`

## Requirements
- R1: After reset, the count reads 0x00, control/status 0x00 and reset control 0x00. `alarm_n` is 1, `rst_req` 0, `irq` 0 and `pwr_grant` 00.
- R2: A write takes effect only when `bus_wdata[15:8]` matches the key of the addressed register. Keys are 0x5A for the count (address 0), 0xA5 for control/status (address 1) and 0x3C for reset control (address 2). Any other write leaves the register unchanged.
- R3: With the enable bit (control bit 5) at 0 the count holds. With it at 1, the count advances by one every 2^k clocks, where the 3-bit rate field (control bits 2:0) selects k from 1, 6, 7, 9, 11, 13, 15, 17.
- R4: In interval mode (control bit 6 = 0), a count passing 0xFF wraps to 0x00. The wrap sets the flag (control bit 7) and raises `irq` until the flag is cleared, and `alarm_n` stays high.
- R5: In watchdog mode (control bit 6 = 1), a count passing 0xFF drives `alarm_n` low for exactly 132 clocks. It also sets the flag and returns the count and control bits 6:0 to 0, so control/status reads 0x80.
- R6: If reset control bit 6 is 1 at a watchdog trip, `rst_req` rises together with the alarm and stays high for exactly 518 clocks. If the bit is 0, `rst_req` stays 0.
- R7: While `alarm_n` is low, writes to all three registers are ignored, even with the correct key.
- R8: A control/status read while `alarm_n` is low does not arm the flag clear. A later write of 0 to the flag then leaves it set.
- R9: The flag clears only on a control/status write with bit 7 = 0 that follows a control/status read made while the flag was 1 and `alarm_n` was high. A write with bit 7 = 1 neither sets nor clears the flag. Clearing the flag also drops `irq`.
- R10: When an overflow and a flag-clearing write fall on the same clock, the flag and `irq` stay set.
- R11: `pwr_grant` follows `slp_req`/`slp_deep` one clock later. It is 00 with no request and 01 for a request without `slp_deep`. A deep request gives 10, except in enabled watchdog mode, where it gives 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 count, 1 control/status, 2 reset control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_wdata | input | 16 | Key in bits 15:8, value in bits 7:0 |
| bus_rdata | output | 8 | Contents of the addressed register |
| slp_req | input | 1 | CPU asks for a low-power state |
| slp_deep | input | 1 | Requested state is standby rather than sleep |
| alarm_n | output | 1 | Active-low watchdog overflow pulse |
| rst_req | output | 1 | Internal reset request |
| irq | output | 1 | Interval overflow interrupt request |
| pwr_grant | output | 2 | Granted power state: 00 run, 01 sleep, 10 standby |

## Verification
Two of the block's functions can land on the same clock edge: an interval overflow setting the flag, and an armed flag-clearing write. The bench arms the clear, leaves the count at 0xFF, and enables the fastest rate with a write that keeps the flag bit at 1. It then issues the clearing write exactly two clocks later, on the first prescaler tick. The flag and `irq` must both still read set, the count must read 0x00, and a fresh read-then-write must then clear the flag normally.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    typedef enum logic [1:0] {
        AL_WATCH     = 2'd0,
        AL_PULSE     = 2'd1,
        AL_PULSE_RST = 2'd2,
        AL_RST_TAIL  = 2'd3
    } alarm_state_t;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'b00,
        PWR_SLEEP = 2'b01,
        PWR_STBY  = 2'b10
    } pwr_state_t;

    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_RSCTL = 2'd2;

    localparam logic [7:0] KEY_COUNT = 8'h5A;
    localparam logic [7:0] KEY_CTRL  = 8'hA5;
    localparam logic [7:0] KEY_RSCTL = 8'h3C;

    function automatic logic [4:0] rate_shift(input logic [2:0] sel);
        logic [4:0] s;
        unique case (sel)
            3'd0: s = 5'd1;
            3'd1: s = 5'd6;
            3'd2: s = 5'd7;
            3'd3: s = 5'd9;
            3'd4: s = 5'd11;
            3'd5: s = 5'd13;
            3'd6: s = 5'd15;
            default: s = 5'd17;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/wdt_rate_div.sv
module wdt_rate_div
    import wdt_guard_pkg::*;
#(
    parameter int PW = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] rate_sel,
    output logic       tick
);
    localparam logic [PW:0] ONE = {{PW{1'b0}}, 1'b1};

    logic [PW-1:0] div_q;
    logic [PW:0]   wide;
    logic [PW-1:0] mask;

    always_comb begin
        wide = (ONE << rate_shift(rate_sel)) - ONE;
        mask = wide[PW-1:0];
    end

    assign tick = run && ((div_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!run)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/wdt_alarm_seq.sv
module wdt_alarm_seq
    import wdt_guard_pkg::*;
#(
    parameter int PULSE_LEN = 132,
    parameter int RST_LEN   = 518
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic rst_en,
    output logic alarm_n,
    output logic rst_req,
    output logic idle
);
    localparam int TW = $clog2(RST_LEN + 1);
    localparam logic [TW-1:0] PULSE_END = TW'(PULSE_LEN - 1);
    localparam logic [TW-1:0] RST_END   = TW'(RST_LEN - 1);

    alarm_state_t state_q, state_d;
    logic [TW-1:0] timer_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_WATCH:     if (trip) state_d = rst_en ? AL_PULSE_RST : AL_PULSE;
            AL_PULSE:     if (timer_q == PULSE_END) state_d = AL_WATCH;
            AL_PULSE_RST: if (timer_q == PULSE_END) state_d = AL_RST_TAIL;
            AL_RST_TAIL:  if (timer_q == RST_END) state_d = AL_WATCH;
            default:      state_d = AL_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AL_WATCH;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= (state_q == AL_WATCH) ? '0 : timer_q + 1'b1;
        end
    end

    always_comb begin
        alarm_n = 1'b1;
        rst_req = 1'b0;
        idle    = 1'b0;
        unique case (state_q)
            AL_WATCH:     idle = 1'b1;
            AL_PULSE:     alarm_n = 1'b0;
            AL_PULSE_RST: begin alarm_n = 1'b0; rst_req = 1'b1; end
            AL_RST_TAIL:  rst_req = 1'b1;
            default:      idle = 1'b1;
        endcase
    end

    // R5: the alarm returns high only after the full pulse count
    assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_n) |-> ($past(timer_q) == PULSE_END));

    // R6: a reset request always starts together with the alarm
    assert_rst_with_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> !alarm_n);

endmodule

// File: rtl/wdt_pwr_decide.sv
module wdt_pwr_decide
    import wdt_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slp_req,
    input  logic       slp_deep,
    input  logic       guarding,
    output logic [1:0] grant
);
    pwr_state_t pwr_q, pwr_d;

    always_comb begin
        if (!slp_req)
            pwr_d = PWR_RUN;
        else if (slp_deep && !guarding)
            pwr_d = PWR_STBY;
        else
            pwr_d = PWR_SLEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pwr_q <= PWR_RUN;
        else
            pwr_q <= pwr_d;
    end

    assign grant = pwr_q;

    // R11: standby is only granted when it was asked for and no watchdog guards
    assert_stby_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == PWR_STBY) |-> $past(slp_req && slp_deep && !guarding));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int CW        = 8,
    parameter int PW        = 17,
    parameter int PULSE_LEN = 132,
    parameter int RST_LEN   = 518
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        slp_req,
    input  logic        slp_deep,
    output logic        alarm_n,
    output logic        rst_req,
    output logic        irq,
    output logic [1:0]  pwr_grant
);
    localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

    logic [CW-1:0] cnt_q;
    logic          flag_q, wdm_q, en_q, rsten_q, armed_q, irq_q;
    logic [2:0]    rate_q;

    logic tick, idle, accept, cnt_wr, ctl_wr, rsc_wr;
    logic at_top, wd_trip, iv_wrap, set_ev, clr_ev, arm_ev;

    wdt_rate_div #(.PW(PW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(en_q), .rate_sel(rate_q), .tick(tick)
    );

    wdt_alarm_seq #(.PULSE_LEN(PULSE_LEN), .RST_LEN(RST_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .trip(wd_trip), .rst_en(rsten_q),
        .alarm_n(alarm_n), .rst_req(rst_req), .idle(idle)
    );

    wdt_pwr_decide u_pwr (
        .clk(clk), .rst_n(rst_n), .slp_req(slp_req), .slp_deep(slp_deep),
        .guarding(wdm_q && en_q), .grant(pwr_grant)
    );

    always_comb begin
        accept  = bus_wr && alarm_n;
        cnt_wr  = accept && (bus_addr == ADDR_COUNT) && (bus_wdata[15:8] == KEY_COUNT);
        ctl_wr  = accept && (bus_addr == ADDR_CTRL)  && (bus_wdata[15:8] == KEY_CTRL);
        rsc_wr  = accept && (bus_addr == ADDR_RSCTL) && (bus_wdata[15:8] == KEY_RSCTL);
        at_top  = tick && (cnt_q == CNT_TOP);
        wd_trip = at_top && wdm_q && idle;
        iv_wrap = at_top && !wdm_q;
        set_ev  = wd_trip || iv_wrap;
        clr_ev  = ctl_wr && !bus_wdata[7] && armed_q;
        arm_ev  = bus_rd && (bus_addr == ADDR_CTRL) && alarm_n && flag_q;
    end

    // count: a keyed write wins over a tick; a watchdog trip clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_wr)
            cnt_q <= bus_wdata[CW-1:0];
        else if (wd_trip)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // control fields: a trip returns them to reset values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdm_q  <= 1'b0;
            en_q   <= 1'b0;
            rate_q <= 3'd0;
        end else if (wd_trip) begin
            wdm_q  <= 1'b0;
            en_q   <= 1'b0;
            rate_q <= 3'd0;
        end else if (ctl_wr) begin
            wdm_q  <= bus_wdata[6];
            en_q   <= bus_wdata[5];
            rate_q <= bus_wdata[2:0];
        end
    end

    // overflow flag, clear arming and interrupt: a set beats a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (set_ev)      flag_q <= 1'b1;
            else if (clr_ev) flag_q <= 1'b0;

            if (set_ev)                          armed_q <= 1'b0;
            else if (ctl_wr && !bus_wdata[7])    armed_q <= 1'b0;
            else if (arm_ev)                     armed_q <= 1'b1;

            if (iv_wrap)     irq_q <= 1'b1;
            else if (clr_ev) irq_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rsten_q <= 1'b0;
        else if (rsc_wr)
            rsten_q <= bus_wdata[6];
    end

    assign irq = irq_q;

    always_comb begin
        unique case (bus_addr)
            ADDR_COUNT: bus_rdata = cnt_q;
            ADDR_CTRL:  bus_rdata = {flag_q, wdm_q, en_q, 2'b00, rate_q};
            ADDR_RSCTL: bus_rdata = {1'b0, rsten_q, 6'b000000};
            default:    bus_rdata = 8'h00;
        endcase
    end

    // R7: writes during the alarm leave every register untouched
    assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_n && bus_wr) |=> ($stable(cnt_q) && $stable(rsten_q)
                                  && $stable({wdm_q, en_q, rate_q})));

    // R3: a halted timer without a count write keeps its value
    assert_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_wr) |=> $stable(cnt_q));

    // R9: the flag only falls after an arming read
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(armed_q));

    // R4: an interval interrupt never rises during the watchdog alarm
    assert_irq_not_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> alarm_n);

endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [7:0]  bus_rdata;
    logic        slp_req = 1'b0;
    logic        slp_deep = 1'b0;
    logic        alarm_n, rst_req, irq;
    logic [1:0]  pwr_grant;

    int total = 0;
    int bad = 0;
    int low_tot = 0;
    int rst_tot = 0;

    wdt_guard uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slp_req(slp_req), .slp_deep(slp_deep), .alarm_n(alarm_n),
        .rst_req(rst_req), .irq(irq), .pwr_grant(pwr_grant)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (!alarm_n) low_tot++;
        if (rst_req)  rst_tot++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] key, input logic [7:0] d);
        bus_addr = a; bus_wdata = {key, d}; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek(0, v); chk("R1 count", v, 8'h00);
        peek(1, v); chk("R1 ctrl", v, 8'h00);
        peek(2, v); chk("R1 rsctl", v, 8'h00);
        chk("R1 alarm_n", alarm_n, 1); chk("R1 rst_req", rst_req, 0);
        chk("R1 irq", irq, 0); chk("R1 grant", pwr_grant, 0);
    endtask

    task automatic t_keys;
        logic [7:0] v;
        wr(0, 8'h00, 8'h33); peek(0, v); chk("R2 count bad key", v, 8'h00);
        wr(0, 8'h5A, 8'h33); peek(0, v); chk("R2 count good key", v, 8'h33);
        wr(1, 8'h5A, 8'h27); peek(1, v); chk("R2 ctrl bad key", v, 8'h00);
        wr(2, 8'hA5, 8'h40); peek(2, v); chk("R2 rsctl bad key", v, 8'h00);
        wr(2, 8'h3C, 8'h40); peek(2, v); chk("R2 rsctl good key", v, 8'h40);
        wr(2, 8'h3C, 8'h00);
    endtask

    task automatic t_rate;
        logic [7:0] v;
        wr(0, 8'h5A, 8'h10); idle(10); peek(0, v); chk("R3 halted", v, 8'h10);
        wr(1, 8'hA5, 8'h20); idle(20);
        wr(1, 8'hA5, 8'h00); peek(0, v); chk("R3 div2 count", v, 8'h1A);
        wr(0, 8'h5A, 8'h00);
        wr(1, 8'hA5, 8'h21); idle(200);
        wr(1, 8'hA5, 8'h00); peek(0, v); chk("R3 div64 count", v, 8'h03);
    endtask

    task automatic t_interval;
        logic [7:0] v;
        int l0;
        l0 = low_tot;
        wr(0, 8'h5A, 8'hFE); wr(1, 8'hA5, 8'h20); idle(2);
        peek(0, v); chk("R4 before wrap", v, 8'hFF); chk("R4 irq before", irq, 0);
        idle(2);
        peek(0, v); chk("R4 wrapped", v, 8'h00);
        peek(1, v); chk("R4 flag", v, 8'hA0); chk("R4 irq", irq, 1);
        idle(20); chk("R4 irq held", irq, 1);
        wr(1, 8'hA5, 8'h80);
        chk("R4 no alarm", low_tot - l0, 0);
    endtask

    task automatic t_clear;
        logic [7:0] v;
        wr(1, 8'hA5, 8'h00); peek(1, v); chk("R9 no read no clear", v, 8'h80);
        chk("R9 irq kept", irq, 1);
        rd(1, v); wr(1, 8'hA5, 8'h80); peek(1, v); chk("R9 bit7=1 keeps", v, 8'h80);
        wr(1, 8'hA5, 8'h00); peek(1, v); chk("R9 cleared", v, 8'h00);
        chk("R9 irq dropped", irq, 0);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        wr(0, 8'h5A, 8'hFE); wr(1, 8'hA5, 8'h20); idle(4);
        wr(1, 8'hA5, 8'h80);
        wr(0, 8'h5A, 8'hFF);
        rd(1, v);
        wr(1, 8'hA5, 8'hA0);
        @(negedge clk);
        wr(1, 8'hA5, 8'h20);
        peek(1, v); chk("R10 flag survives", v, 8'hA0);
        chk("R10 irq survives", irq, 1);
        peek(0, v); chk("R10 count wrapped", v, 8'h00);
        wr(1, 8'hA5, 8'h80);
        rd(1, v); wr(1, 8'hA5, 8'h00); peek(1, v); chk("R10 later clear", v, 8'h00);
    endtask

    task automatic t_wd_plain;
        logic [7:0] v;
        int l0, r0;
        l0 = low_tot; r0 = rst_tot;
        wr(2, 8'h3C, 8'h00);
        wr(0, 8'h5A, 8'hFF); wr(1, 8'hA5, 8'h60); idle(2);
        chk("R5 alarm low", alarm_n, 0);
        peek(1, v); chk("R5 ctrl reset", v, 8'h80);
        peek(0, v); chk("R5 count reset", v, 8'h00);
        wr(0, 8'h5A, 8'h77); peek(0, v); chk("R7 count locked", v, 8'h00);
        wr(2, 8'h3C, 8'h40); peek(2, v); chk("R7 rsctl locked", v, 8'h00);
        wr(1, 8'hA5, 8'h60); peek(1, v); chk("R7 ctrl locked", v, 8'h80);
        rd(1, v);
        idle(200);
        chk("R5 pulse length", low_tot - l0, 132);
        chk("R6 no reset", rst_tot - r0, 0);
        wr(1, 8'hA5, 8'h00); peek(1, v); chk("R8 low read not armed", v, 8'h80);
        rd(1, v); wr(1, 8'hA5, 8'h00); peek(1, v); chk("R9 clear after high", v, 8'h00);
    endtask

    task automatic t_wd_reset;
        logic [7:0] v;
        int l0, r0;
        l0 = low_tot; r0 = rst_tot;
        wr(2, 8'h3C, 8'h40);
        wr(0, 8'h5A, 8'hFF); wr(1, 8'hA5, 8'h60); idle(700);
        chk("R6 pulse length", low_tot - l0, 132);
        chk("R6 reset length", rst_tot - r0, 518);
        rd(1, v); wr(1, 8'hA5, 8'h00);
        wr(2, 8'h3C, 8'h00);
    endtask

    task automatic t_power;
        slp_req = 1'b1; slp_deep = 1'b1; @(negedge clk);
        chk("R11 interval standby", pwr_grant, 2);
        wr(1, 8'hA5, 8'h60); @(negedge clk);
        chk("R11 watchdog demotes", pwr_grant, 1);
        wr(1, 8'hA5, 8'h40); @(negedge clk);
        chk("R11 halted watchdog standby", pwr_grant, 2);
        slp_deep = 1'b0; @(negedge clk);
        chk("R11 light sleep", pwr_grant, 1);
        slp_req = 1'b0; @(negedge clk);
        chk("R11 run", pwr_grant, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog (all R) actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_keys();
        t_rate();
        t_interval();
        t_clear();
        t_collide();
        t_wd_plain();
        t_wd_reset();
        t_power();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule